// File: doc/BRIEF.md
# Private Peripheral Window Decoder for a Multi-Core Cluster

This block is a register-bus slave that serves one 8 KiB private window shared by up to four processor cores. Every access carries the index of the core that issued it. The decoder handles the snoop-control registers itself. It steers interrupt CPU-interface and timer/watchdog accesses to per-core sub-blocks. Each steered access presents a one-hot target select, a local register offset, the strobes and the write data. The read data that comes back from the target is registered into the bus read port.

A sub-block can be reached in two ways. A "self" window resolves to the sub-block of whichever core issued the access. An explicit window names the core through the address. The number of cores actually present is a parameter. It sets the content of the read-only configuration register. Any access that resolves to a core that is not present is dropped: no target is selected, reads return zero and writes change nothing. Offsets that map to nothing behave the same way.

Top module: `privwin_decoder`

## Requirements
- R1: Offset 0x000 holds a control register that can be read and written over the full data width, and it resets to zero.
- R2: Offset 0x004 reads as (cores-1) in bits [3:0], with bits [4+cores-1:4] set to one and all other bits zero. Writes to it have no effect.
- R3: Offset 0x008 (status) and every other offset below 0x100 except 0x000 and 0x004 read as zero.
- R4: Offsets 0x100-0x1FF select the CPU interface of the requesting core (bus_core), and pass bus_addr[7:0] as the local offset.
- R5: Offsets 0x200-0x5FF select the CPU interface of core (addr-0x200)>>8, with local offset bus_addr[7:0].
- R6: Offsets 0x600-0x6FF select timer target index 2*bus_core + bus_addr[5], where bit 5 set means the watchdog. The local offset passed on is bus_addr[3:0].
- R7: Offsets 0x700-0xAFF select timer target index 2*((addr-0x700)>>8) + bus_addr[5], with local offset bus_addr[3:0].
- R8: When the resolved core index is at or above the configured core count, in either a self or an explicit window, no select is asserted. A read returns zero and a write changes no target.
- R9: Offsets 0xB00-0x1FFF select nothing, read as zero and ignore writes.
- R10: Read data appears on bus_rdata one clock after the read strobe and holds until the next read.
- R11: At most one target select is high at a time. Selects are low when no strobe is present, and tgt_wr is only high together with a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte offset inside the private window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DW | Write data |
| bus_core | input | 2 | Index of the core issuing the access |
| bus_rdata | output | DW | Registered read data |
| cpu_sel | output | NUM_CORES | One-hot select of a CPU-interface sub-block |
| cpu_off | output | 8 | Local offset for the CPU interface |
| cpu_rdata | input | NUM_CORES*DW | Read data from the CPU interfaces, core 0 in the low slice |
| tmr_sel | output | 2*NUM_CORES | One-hot select of a timer (even) or watchdog (odd) |
| tmr_off | output | 4 | Local offset for the timer/watchdog |
| tmr_rdata | input | 2*NUM_CORES*DW | Read data from the timer targets, index 0 in the low slice |
| tgt_rd | output | 1 | Read strobe forwarded to the selected target |
| tgt_wr | output | 1 | Write strobe forwarded to the selected target |
| tgt_wdata | output | DW | Write data forwarded to the targets |

## Verification
The bench builds the block with three cores, so the explicit windows for core 3 exist in the address map but have no target behind them. A decoder that only masked the select would still write a neighbour through a wrapped index. One that forgot the self-window check would let core 3 hit a missing CPU interface. Both show up as corrupted stub registers or as non-zero read data. Self and explicit windows are cross-checked against each other by writing through one and reading through the other. A swapped core formula or a timer/watchdog bit taken from the wrong address bit then returns the wrong stub value. The configuration value is compared against a mask computed for three cores, and it is rewritten to show that it cannot be written. The read-data timing is probed before and after the clock edge, which catches a combinational read path.

// File: rtl/privwin_pkg.sv
package privwin_pkg;

   localparam int unsigned MAX_CORES  = 4;
   localparam int unsigned CORE_IDX_W = 2;
   localparam int unsigned TMR_IDX_W  = 3;

   typedef enum logic [2:0] {
      WIN_SCU,
      WIN_CPU_SELF,
      WIN_CPU_EXPL,
      WIN_TMR_SELF,
      WIN_TMR_EXPL,
      WIN_NONE
   } win_e;

endpackage

// File: rtl/privwin_route.sv
module privwin_route
   import privwin_pkg::*;
#(
   parameter int unsigned NUM_CORES = 1,
   parameter int unsigned AW        = 13
) (
   input  logic [AW-1:0]         addr,
   input  logic [CORE_IDX_W-1:0] req_core,
   output win_e                  win,
   output logic [CORE_IDX_W-1:0] core,
   output logic                  core_ok
);

   localparam logic [AW-1:0] B_CPU_SELF = AW'(12'h100);
   localparam logic [AW-1:0] B_CPU_EXPL = AW'(12'h200);
   localparam logic [AW-1:0] B_TMR_SELF = AW'(12'h600);
   localparam logic [AW-1:0] B_TMR_EXPL = AW'(12'h700);
   localparam logic [AW-1:0] B_END      = AW'(12'hB00);

   always_comb begin
      win  = WIN_NONE;
      core = req_core;
      if (addr < B_CPU_SELF) begin
         win = WIN_SCU;
      end else if (addr < B_CPU_EXPL) begin
         win = WIN_CPU_SELF;
      end else if (addr < B_TMR_SELF) begin
         win  = WIN_CPU_EXPL;
         core = CORE_IDX_W'(addr[10:8] - 3'd2);
      end else if (addr < B_TMR_EXPL) begin
         win = WIN_TMR_SELF;
      end else if (addr < B_END) begin
         win  = WIN_TMR_EXPL;
         core = CORE_IDX_W'(addr[11:8] - 4'd7);
      end
   end

   assign core_ok = (32'(core) < 32'(NUM_CORES));

endmodule

// File: rtl/privwin_target_sel.sv
module privwin_target_sel #(
   parameter int unsigned N  = 1,
   parameter int unsigned IW = 2
) (
   input  logic          en,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  sel
);

   for (genvar gi = 0; gi < N; gi++) begin : g_sel
      assign sel[gi] = en && (idx == IW'(gi));
   end

endmodule

// File: rtl/privwin_scu_regs.sv
module privwin_scu_regs #(
   parameter int unsigned NUM_CORES = 1,
   parameter int unsigned DW        = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_we,
   input  logic [DW-1:0] wdata,
   input  logic [7:0]    rd_off,
   output logic [DW-1:0] rdata
);

   localparam int unsigned PRESENT_MASK = (1 << NUM_CORES) - 1;
   localparam logic [DW-1:0] CFG_VALUE  = DW'((PRESENT_MASK << 4) | (NUM_CORES - 1));

   logic [DW-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= wdata;
   end

   always_comb begin
      case (rd_off)
         8'h00:   rdata = ctrl_q;
         8'h04:   rdata = CFG_VALUE;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/privwin_decoder.sv
module privwin_decoder
   import privwin_pkg::*;
#(
   parameter int unsigned NUM_CORES = 1,
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 13
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [AW-1:0]             bus_addr,
   input  logic                      bus_rd,
   input  logic                      bus_wr,
   input  logic [DW-1:0]             bus_wdata,
   input  logic [CORE_IDX_W-1:0]     bus_core,
   output logic [DW-1:0]             bus_rdata,
   output logic [NUM_CORES-1:0]      cpu_sel,
   output logic [7:0]                cpu_off,
   input  logic [NUM_CORES*DW-1:0]   cpu_rdata,
   output logic [2*NUM_CORES-1:0]    tmr_sel,
   output logic [3:0]                tmr_off,
   input  logic [2*NUM_CORES*DW-1:0] tmr_rdata,
   output logic                      tgt_rd,
   output logic                      tgt_wr,
   output logic [DW-1:0]             tgt_wdata
);

   localparam int unsigned NTMR = 2 * NUM_CORES;

   if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
      $error("privwin_decoder: NUM_CORES must be 1..4");
   end
   if (AW < 13) begin : g_bad_aw
      $error("privwin_decoder: AW must cover the 0x2000-byte window");
   end
   if (DW < 8) begin : g_bad_dw
      $error("privwin_decoder: DW must hold the configuration value");
   end

   win_e                  win;
   logic [CORE_IDX_W-1:0] core;
   logic                  core_ok;
   logic                  acc;
   logic                  cpu_en;
   logic                  tmr_en;
   logic [TMR_IDX_W-1:0]  tmr_idx;
   logic [DW-1:0]         scu_rdata;
   logic [DW-1:0]         rd_mux;
   logic [DW-1:0]         rdata_q;

   privwin_route #(.NUM_CORES(NUM_CORES), .AW(AW)) u_route (
      .addr     (bus_addr),
      .req_core (bus_core),
      .win      (win),
      .core     (core),
      .core_ok  (core_ok)
   );

   assign acc     = bus_rd || bus_wr;
   assign cpu_en  = acc && core_ok && (win == WIN_CPU_SELF || win == WIN_CPU_EXPL);
   assign tmr_en  = acc && core_ok && (win == WIN_TMR_SELF || win == WIN_TMR_EXPL);
   assign tmr_idx = {core, bus_addr[5]};

   privwin_target_sel #(.N(NUM_CORES), .IW(CORE_IDX_W)) u_cpu_sel (
      .en  (cpu_en),
      .idx (core),
      .sel (cpu_sel)
   );

   privwin_target_sel #(.N(NTMR), .IW(TMR_IDX_W)) u_tmr_sel (
      .en  (tmr_en),
      .idx (tmr_idx),
      .sel (tmr_sel)
   );

   privwin_scu_regs #(.NUM_CORES(NUM_CORES), .DW(DW)) u_scu (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (bus_wr && win == WIN_SCU && bus_addr[7:0] == 8'h00),
      .wdata   (bus_wdata),
      .rd_off  (bus_addr[7:0]),
      .rdata   (scu_rdata)
   );

   assign cpu_off   = bus_addr[7:0];
   assign tmr_off   = bus_addr[3:0];
   assign tgt_rd    = bus_rd && (cpu_en || tmr_en);
   assign tgt_wr    = bus_wr && (cpu_en || tmr_en);
   assign tgt_wdata = bus_wdata;

   always_comb begin
      rd_mux = (win == WIN_SCU) ? scu_rdata : '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (cpu_sel[i]) rd_mux = rd_mux | cpu_rdata[i*DW +: DW];
      end
      for (int i = 0; i < NTMR; i++) begin
         if (tmr_sel[i]) rd_mux = rd_mux | tmr_rdata[i*DW +: DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/privwin_checker.sv
module privwin_checker
   import privwin_pkg::*;
#(
   parameter int unsigned NUM_CORES = 1,
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 13
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [AW-1:0]          bus_addr,
   input logic                   bus_rd,
   input logic                   bus_wr,
   input logic [CORE_IDX_W-1:0]  bus_core,
   input logic [DW-1:0]          bus_rdata,
   input logic [NUM_CORES-1:0]   cpu_sel,
   input logic [2*NUM_CORES-1:0] tmr_sel,
   input logic                   tgt_wr
);

   function automatic logic [DW-1:0] cfg_expect();
      logic [DW-1:0] v;
      v = DW'(NUM_CORES - 1);
      for (int i = 0; i < NUM_CORES; i++) v[4+i] = 1'b1;
      return v;
   endfunction

   logic any_sel;
   assign any_sel = (|cpu_sel) || (|tmr_sel);

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_sel, tmr_sel})); // R11
   AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_wr |-> any_sel); // R11
   AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |-> !any_sel); // R11
   AST_CFG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AW'(12'h004)) |=> bus_rdata == cfg_expect()); // R2
   AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AW'(12'h008)) |=> bus_rdata == '0); // R3
   AST_DROP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr >= AW'(12'h100) && !any_sel) |=> bus_rdata == '0); // R8
   AST_UNMAPPED_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr >= AW'(12'hB00)) |-> !any_sel); // R9
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R10
   AST_SELF_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && bus_addr >= AW'(12'h100) && bus_addr < AW'(12'h200)
       && 32'(bus_core) < 32'(NUM_CORES))
      |-> cpu_sel == NUM_CORES'(1 << bus_core)); // R4

endmodule

bind privwin_decoder privwin_checker #(.NUM_CORES(NUM_CORES), .DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_core  (bus_core),
   .bus_rdata (bus_rdata),
   .cpu_sel   (cpu_sel),
   .tmr_sel   (tmr_sel),
   .tgt_wr    (tgt_wr)
);

// File: tb/sim_privwin_decoder.sv
`timescale 1ns/1ps
module sim_privwin_decoder;

   localparam int unsigned NC = 3;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 13;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [DW-1:0]     bus_wdata = '0;
   logic [1:0]        bus_core = '0;
   logic [DW-1:0]     bus_rdata;
   logic [NC-1:0]     cpu_sel;
   logic [7:0]        cpu_off;
   logic [NC*DW-1:0]  cpu_rdata;
   logic [2*NC-1:0]   tmr_sel;
   logic [3:0]        tmr_off;
   logic [2*NC*DW-1:0] tmr_rdata;
   logic              tgt_rd;
   logic              tgt_wr;
   logic [DW-1:0]     tgt_wdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   privwin_decoder #(.NUM_CORES(NC), .DW(DW), .AW(AW)) u0 (.*);

   // register stubs for the CPU interfaces and the timer/watchdog targets
   logic [DW-1:0] cmem [NC][256];
   logic [DW-1:0] tmem [2*NC][16];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NC; i++)
            for (int j = 0; j < 256; j++) cmem[i][j] <= '0;
         for (int i = 0; i < 2*NC; i++)
            for (int j = 0; j < 16; j++) tmem[i][j] <= '0;
      end else if (tgt_wr) begin
         for (int i = 0; i < NC; i++)
            if (cpu_sel[i]) cmem[i][cpu_off] <= tgt_wdata;
         for (int i = 0; i < 2*NC; i++)
            if (tmr_sel[i]) tmem[i][tmr_off] <= tgt_wdata;
      end
   end

   always_comb begin
      for (int i = 0; i < NC; i++) cpu_rdata[i*DW +: DW] = cmem[i][cpu_off];
      for (int i = 0; i < 2*NC; i++) tmr_rdata[i*DW +: DW] = tmem[i][tmr_off];
   end

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [1:0] c, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_core = c; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [1:0] c, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_core = c; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      check("R10 reset rdata", bus_rdata, '0);
      check("R11 reset sel", DW'({cpu_sel, tmr_sel}), '0);
      rd(13'h000, 2'd0, v);
      check("R1 ctrl reset", v, '0);
   endtask

   task automatic t_scu();
      logic [DW-1:0] v;
      wr(13'h000, 2'd1, 32'hA5A5_5A5A);
      rd(13'h000, 2'd2, v);
      check("R1 ctrl readback", v, 32'hA5A5_5A5A);
      rd(13'h004, 2'd0, v);
      check("R2 config", v, 32'h0000_0072);
      wr(13'h004, 2'd0, 32'hFFFF_FFFF);
      rd(13'h004, 2'd0, v);
      check("R2 config not writable", v, 32'h0000_0072);
      wr(13'h008, 2'd0, 32'h1234_5678);
      rd(13'h008, 2'd0, v);
      check("R3 status zero", v, '0);
      wr(13'h00C, 2'd0, 32'h1111_1111);
      rd(13'h00C, 2'd0, v);
      check("R3 spare scu zero", v, '0);
      rd(13'h000, 2'd0, v);
      check("R1 ctrl untouched by neighbours", v, 32'hA5A5_5A5A);
   endtask

   task automatic t_cpuif();
      logic [DW-1:0] v;
      @(negedge clk);
      bus_addr = 13'h340; bus_core = 2'd0; bus_wr = 1'b1; bus_wdata = 32'h0;
      #1;
      check("R5 explicit core1 select", DW'(cpu_sel), 32'h2);
      check("R5 local offset", DW'(cpu_off), 32'h40);
      check("R11 timers idle", DW'(tmr_sel), '0);
      bus_wr = 1'b0;
      wr(13'h140, 2'd1, 32'hC0DE_0001);
      rd(13'h340, 2'd0, v);
      check("R4/R5 self write, explicit read", v, 32'hC0DE_0001);
      wr(13'h240, 2'd0, 32'hC0DE_0000);
      rd(13'h140, 2'd0, v);
      check("R4 self read core0", v, 32'hC0DE_0000);
      wr(13'h4FC, 2'd0, 32'hC0DE_0002);
      rd(13'h1FC, 2'd2, v);
      check("R4 self read core2", v, 32'hC0DE_0002);
   endtask

   task automatic t_timer();
      logic [DW-1:0] v;
      @(negedge clk);
      bus_addr = 13'h628; bus_core = 2'd2; bus_rd = 1'b1;
      #1;
      check("R6 self watchdog core2", DW'(tmr_sel), 32'h20);
      check("R6 local offset", DW'(tmr_off), 32'h8);
      bus_rd = 1'b0;
      wr(13'h628, 2'd2, 32'hD06_0002);
      rd(13'h928, 2'd0, v);
      check("R6/R7 watchdog core2", v, 32'hD06_0002);
      wr(13'h704, 2'd0, 32'h71E_0000);
      rd(13'h604, 2'd0, v);
      check("R7 timer core0", v, 32'h71E_0000);
      rd(13'h624, 2'd0, v);
      check("R6 watchdog separate from timer", v, '0);
      rd(13'h614, 2'd0, v);
      check("R6 offset uses low 4 bits", v, 32'h71E_0000);
   endtask

   task automatic t_absent();
      logic [DW-1:0] v;
      @(negedge clk);
      bus_addr = 13'h540; bus_core = 2'd0; bus_wr = 1'b1; bus_wdata = 32'hBAD0_0003;
      #1;
      check("R8 no select for core3", DW'({cpu_sel, tmr_sel}), '0);
      check("R8 no write strobe", DW'(tgt_wr), '0);
      @(negedge clk);
      bus_wr = 1'b0;
      rd(13'h540, 2'd0, v);
      check("R8 absent core reads zero", v, '0);
      rd(13'h240, 2'd0, v);
      check("R8 core0 unchanged", v, 32'hC0DE_0000);
      rd(13'h340, 2'd0, v);
      check("R8 core1 unchanged", v, 32'hC0DE_0001);
      wr(13'hA04, 2'd0, 32'hBAD0_0004);
      rd(13'hA04, 2'd0, v);
      check("R8 absent timer reads zero", v, '0);
      rd(13'h704, 2'd0, v);
      check("R8 timer core0 unchanged", v, 32'h71E_0000);
      wr(13'h140, 2'd3, 32'hBAD0_0005);
      rd(13'h140, 2'd3, v);
      check("R8 self window from absent core", v, '0);
      rd(13'h240, 2'd0, v);
      check("R8 core0 untouched by absent self", v, 32'hC0DE_0000);
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] v;
      wr(13'hB00, 2'd0, 32'hFFFF_0000);
      rd(13'hB00, 2'd0, v);
      check("R9 unmapped B00", v, '0);
      rd(13'h1FFC, 2'd1, v);
      check("R9 unmapped top", v, '0);
      rd(13'h000, 2'd0, v);
      check("R9 ctrl unchanged", v, 32'hA5A5_5A5A);
   endtask

   task automatic t_timing();
      logic [DW-1:0] v;
      rd(13'h004, 2'd0, v);
      @(negedge clk);
      bus_addr = 13'h000; bus_rd = 1'b1;
      #1;
      check("R10 no data before edge", bus_rdata, 32'h0000_0072);
      @(negedge clk);
      bus_rd = 1'b0;
      bus_addr = 13'h004;
      check("R10 data one clock later", bus_rdata, 32'hA5A5_5A5A);
      repeat (3) @(negedge clk);
      check("R10 data held", bus_rdata, 32'hA5A5_5A5A);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_scu();
      t_cpuif();
      t_timer();
      t_absent();
      t_unmapped();
      t_timing();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule